// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock Core

This core keeps the time of day as a running count of elapsed seconds. A separate prescaler supplies a single-cycle `sec_tick` pulse once per second, and the count advances by one on each pulse. Software reaches the core through a small synchronous register bus. Over that bus it can preload the time, program a compare value for the alarm, and manage two interrupt sources: a per-second event and an alarm event. Each source has a sticky status flag and an enable bit, and each drives its own level interrupt line.

Preloading is deferred. A value written to the set-time register is held in a staging register and moves into the running counter only at the next seconds tick. Until that tick, software can read the staged value back through a separate offset. A control word holds two bits, an oscillator enable and a battery-switch enable. The core stores these bits and drives them to output pins without acting on them. Calibration and tick generation are done elsewhere.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, the time count, staged set-time, alarm value, interrupt status, interrupt enables and tick counter are all zero, and both interrupt lines are low. The control word resets to parameter `CTRL_RST` (default 0x0100_0000), masked to its two storage bits.
- R2: On every `sec_tick` without a pending load, the time count (offset 0x10) increases by one and wraps from 0xFFFF_FFFF to 0. Without a tick, the count holds its value.
- R3: A write to offset 0x00 does not change the time count. The next tick after the write loads the written value into the count. A write in the same cycle as a tick is loaded at the following tick, and that tick still performs its normal increment.
- R4: Offset 0x04 reads back the last value written to offset 0x00.
- R5: Interrupt status bit 0 (seconds event) sets on every tick.
- R6: Status bit 1 (alarm event) sets on a tick whose updated time count equals the alarm register at offset 0x18. It sets again on every such tick. Writing the alarm register without a tick never sets it.
- R7: Status (offset 0x20) is write-one-to-clear per bit. A set event in the same cycle as a clear wins.
- R8: Writing a 1 to a bit at offset 0x28 enables that source, and writing a 1 at offset 0x2C disables it. Zero bits leave the enable unchanged. Offset 0x24 reads the enables in bits [1:0].
- R9: `irq_sec_o` equals status bit 0 AND enable bit 0, and `irq_alarm_o` equals status bit 1 AND enable bit 1. Both are levels.
- R10: Control offset 0x40 stores bit 31 (battery-switch enable, pin `batt_sw_en_o`) and bit 24 (oscillator enable, pin `osc_en_o`). All other bits read as 0.
- R11: Read data appears on `bus_rdata` one clock after `bus_rd` and holds until the next read. Unmapped offsets and the write-only offsets 0x00, 0x28 and 0x2C read 0. Writes to read-only offsets have no effect.
- R12: Offset 0x14 returns the number of clock cycles since the last tick. It clears at each tick and saturates at its maximum (0xFFFF by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after `bus_rd` |
| irq_sec_o | output | 1 | Seconds interrupt level |
| irq_alarm_o | output | 1 | Alarm interrupt level |
| osc_en_o | output | 1 | Stored oscillator enable bit |
| batt_sw_en_o | output | 1 | Stored battery-switch enable bit |

## Verification
A wrong staging flag shows up at the time register within one tick. The count would take the staged value too early, never take it, or take it twice, and the read at offset 0x10 right after that tick would show it. A status or enable bit that is stuck or lost appears on the interrupt pins in the cycle after the bus write or tick that should have moved it. A compare made against the old count instead of the updated one raises the alarm flag one second late, and the status read after the matching tick reveals it. The cycle counter at 0x14 is read at known distances from a tick, which exposes any off-by-one in its clear or saturation.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

   localparam int unsigned OFS_W = 7;

   typedef enum logic [OFS_W-1:0] {
      OFS_SET_WR = 7'h00,
      OFS_SET_RD = 7'h04,
      OFS_TIME   = 7'h10,
      OFS_TICK   = 7'h14,
      OFS_ALARM  = 7'h18,
      OFS_STS    = 7'h20,
      OFS_MASK   = 7'h24,
      OFS_EN     = 7'h28,
      OFS_DIS    = 7'h2C,
      OFS_CTRL   = 7'h40
   } rtc_ofs_e;

   localparam int unsigned SRC_SEC   = 0;
   localparam int unsigned SRC_ALARM = 1;
   localparam int unsigned N_SRC     = 2;

   localparam int unsigned CTRL_BATT_BIT = 31;
   localparam int unsigned CTRL_OSC_BIT  = 24;

   typedef struct packed {
      logic set_we;
      logic alarm_we;
      logic sts_we;
      logic en_we;
      logic dis_we;
      logic ctrl_we;
   } rtc_wr_strb_t;

endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
   import rtc_sec_pkg::*;
#(
   parameter int unsigned TIME_W      = 32,
   parameter int unsigned TICK_W      = 16,
   parameter bit          TICK_CNT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              set_we,
   input  logic [TIME_W-1:0] set_wdata,
   input  logic [TIME_W-1:0] alarm_val,
   output logic [TIME_W-1:0] cur_time,
   output logic [TIME_W-1:0] set_val,
   output logic [TICK_W-1:0] tick_cnt,
   output logic              alarm_hit
);

   localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

   logic [TIME_W-1:0] cur_q;
   logic [TIME_W-1:0] set_q;
   logic              pend_q;
   logic [TIME_W-1:0] next_time;

   // a staged value replaces the increment for exactly one tick
   always_comb begin
      next_time = pend_q ? set_q : cur_q + TIME_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         set_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (tick) begin
            cur_q <= next_time;
         end
         if (set_we) begin
            set_q  <= set_wdata;
            pend_q <= 1'b1;
         end else if (tick) begin
            pend_q <= 1'b0;
         end
      end
   end

   // compare against the value the count takes at this edge
   assign alarm_hit = tick && (next_time == alarm_val);
   assign cur_time  = cur_q;
   assign set_val   = set_q;

   generate
      if (TICK_CNT_EN) begin : g_tick_cnt
         logic [TICK_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (tick) begin
               cnt_q <= '0;
            end else if (cnt_q != TICK_MAX) begin
               cnt_q <= cnt_q + TICK_W'(1);
            end
         end
         assign tick_cnt = cnt_q;

         a_r12_tick_clears : assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> (tick_cnt == '0));
         a_r12_saturate : assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && tick_cnt == TICK_MAX) |=> (tick_cnt == TICK_MAX));
      end else begin : g_no_tick_cnt
         assign tick_cnt = '0;
      end
   endgenerate

   a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cur_q));
   a_r2_increment : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !pend_q) |=> (cur_q == $past(cur_q) + TIME_W'(1)));
   a_r3_load : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pend_q) |=> (cur_q == $past(set_q)));
   a_r3_stay_pending : assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> pend_q);

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_sec_pkg::*;
#(
   parameter int unsigned NSRC = N_SRC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_ev,
   input  logic            clr_we,
   input  logic            en_we,
   input  logic            dis_we,
   input  logic [NSRC-1:0] wbits,
   output logic [NSRC-1:0] sts,
   output logic [NSRC-1:0] en,
   output logic [NSRC-1:0] irq
);

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         logic sts_q;
         logic en_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sts_q <= 1'b0;
            end else if (set_ev[i]) begin
               sts_q <= 1'b1;
            end else if (clr_we && wbits[i]) begin
               sts_q <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q <= 1'b0;
            end else if (en_we && wbits[i]) begin
               en_q <= 1'b1;
            end else if (dis_we && wbits[i]) begin
               en_q <= 1'b0;
            end
         end

         assign sts[i] = sts_q;
         assign en[i]  = en_q;
         assign irq[i] = sts_q & en_q;

         a_r7_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> sts[i]);
         a_r7_w1c : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wbits[i] && !set_ev[i]) |=> !sts[i]);
         a_r8_enable : assert property (@(posedge clk) disable iff (!rst_n)
            (en_we && wbits[i]) |=> en[i]);
         a_r8_disable : assert property (@(posedge clk) disable iff (!rst_n)
            (dis_we && wbits[i]) |=> !en[i]);
      end
   endgenerate

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_sec_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned TIME_W   = 32,
   parameter int unsigned TICK_W   = 16,
   parameter logic [31:0] CTRL_RST = 32'h0100_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output rtc_wr_strb_t      strb,
   output logic [TIME_W-1:0] alarm_val,
   output logic [DATA_W-1:0] ctrl_val,
   input  logic [TIME_W-1:0] cur_time,
   input  logic [TIME_W-1:0] set_val,
   input  logic [TICK_W-1:0] tick_cnt,
   input  logic [N_SRC-1:0]  sts,
   input  logic [N_SRC-1:0]  en
);

   localparam logic [DATA_W-1:0] CTRL_KEEP =
      (DATA_W'(1) << CTRL_BATT_BIT) | (DATA_W'(1) << CTRL_OSC_BIT);
   localparam logic [DATA_W-1:0] CTRL_INIT = DATA_W'(CTRL_RST) & CTRL_KEEP;

   function automatic logic at(input logic [ADDR_W-1:0] a, input rtc_ofs_e o);
      return a == ADDR_W'(int'(o));
   endfunction

   logic [TIME_W-1:0] alarm_q;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      strb.set_we   = bus_wr && at(bus_addr, OFS_SET_WR);
      strb.alarm_we = bus_wr && at(bus_addr, OFS_ALARM);
      strb.sts_we   = bus_wr && at(bus_addr, OFS_STS);
      strb.en_we    = bus_wr && at(bus_addr, OFS_EN);
      strb.dis_we   = bus_wr && at(bus_addr, OFS_DIS);
      strb.ctrl_we  = bus_wr && at(bus_addr, OFS_CTRL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= '0;
         ctrl_q  <= CTRL_INIT;
      end else begin
         if (strb.alarm_we) begin
            alarm_q <= bus_wdata[TIME_W-1:0];
         end
         if (strb.ctrl_we) begin
            ctrl_q <= bus_wdata & CTRL_KEEP;
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      if (at(bus_addr, OFS_SET_RD)) rd_mux = DATA_W'(set_val);
      if (at(bus_addr, OFS_TIME))   rd_mux = DATA_W'(cur_time);
      if (at(bus_addr, OFS_TICK))   rd_mux = DATA_W'(tick_cnt);
      if (at(bus_addr, OFS_ALARM))  rd_mux = DATA_W'(alarm_q);
      if (at(bus_addr, OFS_STS))    rd_mux = DATA_W'(sts);
      if (at(bus_addr, OFS_MASK))   rd_mux = DATA_W'(en);
      if (at(bus_addr, OFS_CTRL))   rd_mux = ctrl_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = rdata_q;
   assign alarm_val = alarm_q;
   assign ctrl_val  = ctrl_q;

   a_r11_rdata_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   a_r10_ctrl_reserved : assert property (@(posedge clk) disable iff (!rst_n)
      strb.ctrl_we |=> ((ctrl_val & ~CTRL_KEEP) == '0));
   a_r6_alarm_store : assert property (@(posedge clk) disable iff (!rst_n)
      strb.alarm_we |=> (alarm_val == $past(bus_wdata[TIME_W-1:0])));

endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
   import rtc_sec_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned TIME_W      = 32,
   parameter int unsigned TICK_W      = 16,
   parameter bit          TICK_CNT_EN = 1'b1,
   parameter logic [31:0] CTRL_RST    = 32'h0100_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_sec_o,
   output logic              irq_alarm_o,
   output logic              osc_en_o,
   output logic              batt_sw_en_o
);

   generate
      if (ADDR_W < OFS_W) begin : g_bad_addr
         $error("rtc_sec_core: ADDR_W too small for the register map");
      end
      if (DATA_W < 32) begin : g_bad_data
         $error("rtc_sec_core: DATA_W must hold control bit 31");
      end
      if (TIME_W > DATA_W || TIME_W < 2) begin : g_bad_time
         $error("rtc_sec_core: TIME_W out of range");
      end
      if (TICK_W > DATA_W || TICK_W < 1) begin : g_bad_tick
         $error("rtc_sec_core: TICK_W out of range");
      end
   endgenerate

   rtc_wr_strb_t      strb;
   logic [TIME_W-1:0] alarm_val;
   logic [DATA_W-1:0] ctrl_val;
   logic [TIME_W-1:0] cur_time;
   logic [TIME_W-1:0] set_val;
   logic [TICK_W-1:0] tick_cnt;
   logic              alarm_hit;
   logic [N_SRC-1:0]  sts;
   logic [N_SRC-1:0]  en;
   logic [N_SRC-1:0]  irq;
   logic [N_SRC-1:0]  set_ev;

   rtc_regfile #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .TIME_W   (TIME_W),
      .TICK_W   (TICK_W),
      .CTRL_RST (CTRL_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .strb      (strb),
      .alarm_val (alarm_val),
      .ctrl_val  (ctrl_val),
      .cur_time  (cur_time),
      .set_val   (set_val),
      .tick_cnt  (tick_cnt),
      .sts       (sts),
      .en        (en)
   );

   rtc_sec_counter #(
      .TIME_W      (TIME_W),
      .TICK_W      (TICK_W),
      .TICK_CNT_EN (TICK_CNT_EN)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .set_we    (strb.set_we),
      .set_wdata (bus_wdata[TIME_W-1:0]),
      .alarm_val (alarm_val),
      .cur_time  (cur_time),
      .set_val   (set_val),
      .tick_cnt  (tick_cnt),
      .alarm_hit (alarm_hit)
   );

   always_comb begin
      set_ev            = '0;
      set_ev[SRC_SEC]   = sec_tick;
      set_ev[SRC_ALARM] = alarm_hit;
   end

   rtc_irq_ctrl #(
      .NSRC (N_SRC)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (set_ev),
      .clr_we (strb.sts_we),
      .en_we  (strb.en_we),
      .dis_we (strb.dis_we),
      .wbits  (bus_wdata[N_SRC-1:0]),
      .sts    (sts),
      .en     (en),
      .irq    (irq)
   );

   assign irq_sec_o    = irq[SRC_SEC];
   assign irq_alarm_o  = irq[SRC_ALARM];
   assign osc_en_o     = ctrl_val[CTRL_OSC_BIT];
   assign batt_sw_en_o = ctrl_val[CTRL_BATT_BIT];

   a_r4_set_capture : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(int'(OFS_SET_WR)))
      |=> (set_val == $past(bus_wdata[TIME_W-1:0])));
   a_r8_en_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !(strb.en_we || strb.dis_we) |=> $stable(en));
   a_r5_sec_flag : assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> sts[SRC_SEC]);
   a_r9_irq_gated : assert property (@(posedge clk) disable iff (!rst_n)
      (!en[SRC_ALARM] && !en[SRC_SEC]) |-> (!irq_alarm_o && !irq_sec_o));

endmodule

// File: tb/rtc_sec_core_tb_top.sv
module rtc_sec_core_tb_top;

   localparam logic [7:0] A_SET_WR = 8'h00;
   localparam logic [7:0] A_SET_RD = 8'h04;
   localparam logic [7:0] A_TIME   = 8'h10;
   localparam logic [7:0] A_TICK   = 8'h14;
   localparam logic [7:0] A_ALARM  = 8'h18;
   localparam logic [7:0] A_STS    = 8'h20;
   localparam logic [7:0] A_MASK   = 8'h24;
   localparam logic [7:0] A_EN     = 8'h28;
   localparam logic [7:0] A_DIS    = 8'h2C;
   localparam logic [7:0] A_CTRL   = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_sec_o;
   logic        irq_alarm_o;
   logic        osc_en_o;
   logic        batt_sw_en_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rtc_sec_core dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sec_tick     (sec_tick),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .irq_sec_o    (irq_sec_o),
      .irq_alarm_o  (irq_alarm_o),
      .osc_en_o     (osc_en_o),
      .batt_sw_en_o (batt_sw_en_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = tk;
      @(negedge clk);
      bus_wr = 1'b0; sec_tick = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic tick();
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_TIME, v);  chk("R1 time", v, 32'h0);
      rd(A_STS, v);   chk("R1 status", v, 32'h0);
      rd(A_MASK, v);  chk("R1 mask", v, 32'h0);
      rd(A_ALARM, v); chk("R1 alarm", v, 32'h0);
      rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0100_0000);
      chk("R1 irq pins", {30'h0, irq_alarm_o, irq_sec_o}, 32'h0);
      chk("R1 ctrl pins", {30'h0, batt_sw_en_o, osc_en_o}, 32'h1);
   endtask

   task automatic t_count();
      logic [31:0] v;
      repeat (3) tick();
      rd(A_TIME, v); chk("R2 three ticks", v, 32'd3);
      repeat (4) @(negedge clk);
      rd(A_TIME, v); chk("R2 hold without tick", v, 32'd3);
   endtask

   task automatic t_settime();
      logic [31:0] v;
      wr(A_SET_WR, 32'd1000);
      rd(A_TIME, v);   chk("R3 no load at write", v, 32'd3);
      rd(A_SET_RD, v); chk("R4 readback", v, 32'd1000);
      tick();
      rd(A_TIME, v);   chk("R3 loaded at tick", v, 32'd1000);
      tick();
      rd(A_TIME, v);   chk("R3 counts after load", v, 32'd1001);
      wr(A_SET_WR, 32'd5000, 1'b1);
      rd(A_TIME, v);   chk("R3 write with tick increments", v, 32'd1002);
      tick();
      rd(A_TIME, v);   chk("R3 write with tick loads next", v, 32'd5000);
   endtask

   task automatic t_wrap();
      logic [31:0] v;
      wr(A_SET_WR, 32'hFFFF_FFFF);
      tick();
      rd(A_TIME, v); chk("R2 max value", v, 32'hFFFF_FFFF);
      tick();
      rd(A_TIME, v); chk("R2 wrap to zero", v, 32'h0);
   endtask

   task automatic t_status();
      logic [31:0] v;
      wr(A_STS, 32'h3);
      rd(A_STS, v); chk("R7 w1c both", v, 32'h0);
      tick();
      rd(A_STS, v); chk("R5 sec flag on tick", v, 32'h1);
      wr(A_STS, 32'h1, 1'b1);
      rd(A_STS, v); chk("R7 set wins over clear", v, 32'h1);
      wr(A_STS, 32'h1);
      rd(A_STS, v); chk("R7 clear sec", v, 32'h0);
   endtask

   task automatic t_alarm();
      logic [31:0] v;
      wr(A_ALARM, 32'd2);
      rd(A_STS, v);   chk("R6 no flag without tick", v, 32'h0);
      wr(A_ALARM, 32'd50);
      rd(A_ALARM, v); chk("R6 alarm readback", v, 32'd50);
      wr(A_SET_WR, 32'd49);
      tick();
      rd(A_STS, v);   chk("R6 no flag before match", v, 32'h1);
      tick();
      rd(A_STS, v);   chk("R6 flag on match", v, 32'h3);
      wr(A_STS, 32'h3);
      wr(A_SET_WR, 32'd50);
      tick();
      rd(A_STS, v);   chk("R6 reasserts on reload", v, 32'h3);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      wr(A_EN, 32'h2);
      rd(A_MASK, v); chk("R8 enable alarm", v, 32'h2);
      chk("R9 alarm line only", {30'h0, irq_alarm_o, irq_sec_o}, 32'h2);
      wr(A_EN, 32'h1);
      rd(A_MASK, v); chk("R8 enable sec", v, 32'h3);
      chk("R9 both lines", {30'h0, irq_alarm_o, irq_sec_o}, 32'h3);
      wr(A_DIS, 32'h2);
      rd(A_MASK, v); chk("R8 disable alarm", v, 32'h1);
      chk("R9 alarm line off", {30'h0, irq_alarm_o, irq_sec_o}, 32'h1);
      wr(A_EN, 32'h0);
      rd(A_MASK, v); chk("R8 zero bits no effect", v, 32'h1);
      wr(A_STS, 32'h1);
      chk("R9 sec line follows status", {31'h0, irq_sec_o}, 32'h0);
      wr(A_DIS, 32'h1);
      rd(A_MASK, v); chk("R8 all disabled", v, 32'h0);
   endtask

   task automatic t_ctrl();
      logic [31:0] v;
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, v); chk("R10 ctrl storage bits", v, 32'h8100_0000);
      chk("R10 ctrl pins set", {30'h0, batt_sw_en_o, osc_en_o}, 32'h3);
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v); chk("R10 ctrl cleared", v, 32'h0);
      chk("R10 ctrl pins clear", {30'h0, batt_sw_en_o, osc_en_o}, 32'h0);
   endtask

   task automatic t_bus();
      logic [31:0] v;
      logic [31:0] t0;
      rd(A_TIME, t0);
      rd(8'h30, v);    chk("R11 unmapped reads zero", v, 32'h0);
      rd(A_SET_WR, v); chk("R11 set write offset reads zero", v, 32'h0);
      rd(A_EN, v);     chk("R11 enable offset reads zero", v, 32'h0);
      wr(A_TIME, 32'hDEAD_BEEF);
      rd(A_TIME, v);   chk("R11 time read-only", v, t0);
      rd(A_CTRL, v);
      wr(A_CTRL, 32'h8000_0000);
      repeat (3) @(negedge clk);
      chk("R11 rdata holds between reads", bus_rdata, 32'h0);
   endtask

   task automatic t_tick_cnt();
      logic [31:0] v;
      tick();
      rd(A_TICK, v); chk("R12 zero right after tick", v, 32'd0);
      tick();
      repeat (5) @(negedge clk);
      rd(A_TICK, v); chk("R12 counts cycles", v, 32'd5);
      tick();
      repeat (65540) @(negedge clk);
      rd(A_TICK, v); chk("R12 saturates", v, 32'h0000_FFFF);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_settime();
      t_wrap();
      t_status();
      t_alarm();
      t_enable();
      t_ctrl();
      t_bus();
      t_tick_cnt();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule